// File: doc/BRIEF.md
# One-Time-Programmable Fuse Array Controller

This block is a byte-wide register target that fronts an on-chip one-time-programmable fuse store. The store is organised as 8 banks of 32 rows, one byte per row. It is held in two inferred memories: the fuse cells themselves and a shadow copy that software can read directly.

Software selects a location by loading two address bytes: one carries the bank and the upper row bits, the other carries the lower row bits and a bit index. It then writes a command code. One command senses a whole row into a data register. The other blows one selected bit, and it does so only while a protection register holds an unlock key. While an operation runs, a busy bit reads high. When the operation ends, a done flag and any error flags are raised. Both kinds of flag are cleared by writing ones to them.

After each program operation the shadow copy of the affected row is refreshed. Reads of the shadow window therefore always agree with a fresh sense. Fuse contents survive the block's reset.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: The bank is taken from bits [5:3] of the upper address byte (offset 0x10). The row is the concatenation of bits [2:0] of that byte (row bits 7..5) with bits [7:3] of the lower address byte (offset 0x14). The bit index is bits [2:0] of the lower address byte.
- R2: Writing 0x08 to the command register (offset 0x0C) while idle senses the addressed row. When the operation ends, the data register (offset 0x18) holds the row byte and status bit 1 is set.
- R3: Writing 0x71 to the command register while idle, with the key 0xAA in the protection register (offset 0x1C), sets exactly the addressed bit of the addressed row. When the operation ends, status bit 0 is set.
- R4: Status bit 7 (status at offset 0x00) reads 1 for exactly SENSE_CYC cycles after a sense command is accepted, and for PROG_CYC cycles after a program command is accepted. After that it reads 0.
- R5: A program command accepted while the protection register does not hold 0xAA leaves the array unchanged. It sets error bit 3 (error register at offset 0x08, value 0x08), and it still ends with busy low and status bit 0 set.
- R6: A fuse bit never returns from 1 to 0. Programming a bit that is already set leaves the row unchanged, and programming one bit leaves the other bits of the row as they were.
- R7: Status bits [1:0] and all error bits are cleared by writing 1 to them. If such a write lands in the same cycle as an operation's completion, the newly raised flag stays set.
- R8: A row index of 32 or more is out of range. It sets error bit 1 (0x02), changes no fuse, and a sense of it leaves 0x00 in the data register.
- R9: The shadow byte of bank n, row r, is read at byte address 0x800 + 0x400*n + 4*r. It matches the fuse row after every program. Writes to the window have no effect.
- R10: Command writes while busy are ignored, and so are command values other than 0x08 and 0x71.
- R11: Reset clears all registers to 0x00 but leaves the fuse contents and the shadow copy untouched.
- R12: Read data appears on bus_rdata in the cycle after bus_re is sampled. The mask register (offset 0x04) stores and returns any byte, and unmapped addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid one cycle after bus_re |

## Verification
Two functions can fall in the same cycle: software clearing a status or error flag, and an operation raising that same flag as it completes. The bench counts clock edges from the command write so that a write-one-to-clear to the status register lands exactly on the finishing edge of a sense. It does the same with the error register on the finishing edge of a locked program. It then reads the flag back and expects it still set. A second overlap is a command write arriving while an operation is already busy. The bench judges that case by the done flag that results and by a fresh sense showing the row unchanged.

// File: rtl/otp_pkg.sv
package otp_pkg;
  localparam logic [7:0] CMD_SENSE  = 8'h08;
  localparam logic [7:0] CMD_PROG   = 8'h71;
  localparam logic [7:0] UNLOCK_KEY = 8'hAA;
  localparam logic [7:0] ERR_LOCKED = 8'h08;
  localparam logic [7:0] ERR_RANGE  = 8'h02;

  localparam int OFF_STATUS = 'h00;
  localparam int OFF_MASK   = 'h04;
  localparam int OFF_ERR    = 'h08;
  localparam int OFF_CMD    = 'h0C;
  localparam int OFF_ADDR_H = 'h10;
  localparam int OFF_ADDR_L = 'h14;
  localparam int OFF_DATA   = 'h18;
  localparam int OFF_PROT   = 'h1C;

  typedef logic [7:0] byte_t;
endpackage

// File: rtl/otp_byte_mem.sv
module otp_byte_mem #(
  parameter int DEPTH = 256
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [7:0]               wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [7:0]               rdata
);
  logic [7:0] mem [DEPTH];

  // power-up state of unblown fuses
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/otp_seq.sv
module otp_seq #(
  parameter int BANKS     = 8,
  parameter int ROWS      = 32,
  parameter int SENSE_CYC = 8,
  parameter int PROG_CYC  = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start_sense,
  input  logic                          start_prog,
  input  logic [5:0]                    addr_hi,
  input  logic [7:0]                    addr_lo,
  input  logic                          unlocked,
  output logic                          busy,
  output logic                          fin,
  output logic                          op_prog,
  output logic                          op_locked,
  output logic                          op_range_bad,
  output logic [$clog2(BANKS*ROWS)-1:0] op_idx,
  output logic [2:0]                    op_bit
);
  localparam int IDX_W = $clog2(BANKS*ROWS);
  localparam int CNT_W = $clog2(PROG_CYC);

  logic [CNT_W-1:0] cnt;
  logic [7:0]       row_full;
  logic [2:0]       bank_sel;
  logic             range_bad;
  logic [IDX_W-1:0] idx_new;

  assign bank_sel  = addr_hi[5:3];
  assign row_full  = {addr_hi[2:0], addr_lo[7:3]};
  assign range_bad = (32'(row_full) >= ROWS) || (32'(bank_sel) >= BANKS);
  assign idx_new   = IDX_W'(32'(bank_sel) * ROWS + 32'(row_full));
  assign fin       = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy         <= 1'b0;
      cnt          <= '0;
      op_prog      <= 1'b0;
      op_locked    <= 1'b0;
      op_range_bad <= 1'b0;
      op_idx       <= '0;
      op_bit       <= '0;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end else if (start_sense || start_prog) begin
      busy         <= 1'b1;
      cnt          <= start_prog ? CNT_W'(PROG_CYC - 1) : CNT_W'(SENSE_CYC - 1);
      op_prog      <= start_prog;
      op_locked    <= !unlocked;
      op_range_bad <= range_bad;
      op_idx       <= idx_new;
      op_bit       <= addr_lo[2:0];
    end
  end

  // checker counter: cycles spent busy in the current operation
  logic [CNT_W:0] run_len;
  always_ff @(posedge clk) begin
    if (rst || !busy) run_len <= '0;
    else              run_len <= run_len + 1'b1;
  end

  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (rst)
    busy |-> (run_len < (CNT_W+1)'(PROG_CYC))) else $error("busy too long"); // R4

  AST_CMD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy && (start_sense || start_prog)) |=> ($stable(op_idx) && $stable(op_prog))) else $error("cmd taken while busy"); // R10
endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl #(
  parameter int BANKS      = 8,
  parameter int ROWS       = 32,
  parameter int SENSE_CYC  = 8,
  parameter int PROG_CYC   = 32,
  parameter int ADDR_W     = 14,
  parameter int WIN_BASE   = 'h800,
  parameter int WIN_STRIDE = 'h400
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata
);
  import otp_pkg::*;

  localparam int DEPTH    = BANKS * ROWS;
  localparam int IDX_W    = $clog2(DEPTH);
  localparam int STRIDE_W = $clog2(WIN_STRIDE);

  // register decode
  logic hit_status, hit_mask, hit_err, hit_cmd, hit_ahi, hit_alo, hit_data, hit_prot;
  assign hit_status = bus_addr == ADDR_W'(OFF_STATUS);
  assign hit_mask   = bus_addr == ADDR_W'(OFF_MASK);
  assign hit_err    = bus_addr == ADDR_W'(OFF_ERR);
  assign hit_cmd    = bus_addr == ADDR_W'(OFF_CMD);
  assign hit_ahi    = bus_addr == ADDR_W'(OFF_ADDR_H);
  assign hit_alo    = bus_addr == ADDR_W'(OFF_ADDR_L);
  assign hit_data   = bus_addr == ADDR_W'(OFF_DATA);
  assign hit_prot   = bus_addr == ADDR_W'(OFF_PROT);

  byte_t      mask_q, err_q, ahi_q, alo_q, data_q, prot_q, reg_q;
  logic [1:0] done_q;
  logic       win_q;

  // sequencer
  logic             busy, fin, op_prog, op_locked, op_range_bad;
  logic [IDX_W-1:0] op_idx;
  logic [2:0]       op_bit;
  logic             go_sense, go_prog;

  assign go_sense = bus_we && hit_cmd && (bus_wdata == CMD_SENSE);
  assign go_prog  = bus_we && hit_cmd && (bus_wdata == CMD_PROG);

  otp_seq #(
    .BANKS(BANKS), .ROWS(ROWS), .SENSE_CYC(SENSE_CYC), .PROG_CYC(PROG_CYC)
  ) seq_i (
    .clk(clk), .rst(rst),
    .start_sense(go_sense), .start_prog(go_prog),
    .addr_hi(ahi_q[5:0]), .addr_lo(alo_q),
    .unlocked(prot_q == UNLOCK_KEY),
    .busy(busy), .fin(fin), .op_prog(op_prog), .op_locked(op_locked),
    .op_range_bad(op_range_bad), .op_idx(op_idx), .op_bit(op_bit)
  );

  // fuse cells and shadow copy
  logic [7:0] fuse_q, shadow_q, cell_wdata;
  logic       cell_we;

  assign cell_we    = fin && op_prog && !op_locked && !op_range_bad;
  assign cell_wdata = fuse_q | (8'h01 << op_bit);

  otp_byte_mem #(.DEPTH(DEPTH)) fuse_i (
    .clk(clk), .we(cell_we), .waddr(op_idx), .wdata(cell_wdata),
    .raddr(op_idx), .rdata(fuse_q)
  );

  // shadow window decode
  logic [ADDR_W-1:0]   win_off, win_bank;
  logic [STRIDE_W-1:0] win_inner;
  logic                win_hit;
  logic [IDX_W-1:0]    win_idx;

  assign win_off   = bus_addr - ADDR_W'(WIN_BASE);
  assign win_bank  = win_off >> STRIDE_W;
  assign win_inner = win_off[STRIDE_W-1:0];
  assign win_hit   = (bus_addr >= ADDR_W'(WIN_BASE))
                  && (win_off < ADDR_W'(BANKS * WIN_STRIDE))
                  && (win_inner[1:0] == 2'b00)
                  && (win_inner < STRIDE_W'(ROWS * 4));
  assign win_idx   = IDX_W'(32'(win_bank) * ROWS + 32'(win_inner >> 2));

  otp_byte_mem #(.DEPTH(DEPTH)) shadow_i (
    .clk(clk), .we(cell_we), .waddr(op_idx), .wdata(cell_wdata),
    .raddr(win_idx), .rdata(shadow_q)
  );

  // completion flags
  logic [1:0] done_set;
  byte_t      err_set, reg_rd_val;

  assign done_set = fin ? (op_prog ? 2'b01 : 2'b10) : 2'b00;
  assign err_set  = fin ? ((op_prog && op_locked ? ERR_LOCKED : 8'h00)
                         | (op_range_bad ? ERR_RANGE : 8'h00)) : 8'h00;

  always_comb begin
    reg_rd_val = 8'h00;
    if (hit_status)    reg_rd_val = {busy, 5'b00000, done_q};
    else if (hit_mask) reg_rd_val = mask_q;
    else if (hit_err)  reg_rd_val = err_q;
    else if (hit_ahi)  reg_rd_val = ahi_q;
    else if (hit_alo)  reg_rd_val = alo_q;
    else if (hit_data) reg_rd_val = data_q;
    else if (hit_prot) reg_rd_val = prot_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= '0;
      mask_q <= '0;
      err_q  <= '0;
      ahi_q  <= '0;
      alo_q  <= '0;
      data_q <= '0;
      prot_q <= '0;
      reg_q  <= '0;
      win_q  <= 1'b0;
    end else begin
      done_q <= (done_q & ~((bus_we && hit_status) ? bus_wdata[1:0] : 2'b00)) | done_set;
      err_q  <= (err_q & ~((bus_we && hit_err) ? bus_wdata : 8'h00)) | err_set;
      if (bus_we && hit_mask) mask_q <= bus_wdata;
      if (bus_we && hit_ahi)  ahi_q  <= bus_wdata;
      if (bus_we && hit_alo)  alo_q  <= bus_wdata;
      if (bus_we && hit_prot) prot_q <= bus_wdata;
      if (fin && !op_prog)    data_q <= op_range_bad ? 8'h00 : fuse_q;
      if (bus_re) begin
        reg_q <= reg_rd_val;
        win_q <= win_hit;
      end
    end
  end

  assign bus_rdata = win_q ? shadow_q : reg_q;

  AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !$past(rst)) |-> (done_q != 2'b00)) else $error("no done flag"); // R3

  AST_LOCKED_FLAG: assert property (@(posedge clk) disable iff (rst)
    (fin && op_prog && op_locked) |=> err_q[3]) else $error("locked error missing"); // R5

  AST_RANGE_FLAG: assert property (@(posedge clk) disable iff (rst)
    (fin && op_range_bad) |=> err_q[1]) else $error("range error missing"); // R8
endmodule

// File: tb/otp_fuse_ctrl_tb_top.sv
module otp_fuse_ctrl_tb_top;
  import otp_pkg::*;

  localparam int BANKS = 8;
  localparam int ROWS  = 32;
  localparam int SC    = 3;
  localparam int PC    = 6;
  localparam int AW    = 14;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_we = 1'b0;
  logic          bus_re = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    bus_rdata;

  int checks = 0;
  int fails  = 0;
  logic [7:0] model [BANKS*ROWS];

  always #4 clk = ~clk;

  otp_fuse_ctrl #(
    .BANKS(BANKS), .ROWS(ROWS), .SENSE_CYC(SC), .PROG_CYC(PC), .ADDR_W(AW)
  ) dut_i (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk);
    bus_re = 1'b1; bus_addr = AW'(a);
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int k = 0; k < 200; k++) begin
      rd(OFF_STATUS, s);
      if (!s[7]) break;
    end
  endtask

  function automatic int shadow_addr(input int b, input int r);
    return 'h800 + 'h400 * b + 4 * r;
  endfunction

  task automatic set_addr(input int b, input int r, input int bitpos);
    wr(OFF_ADDR_H, 8'((b << 3) | (r >> 5)));
    wr(OFF_ADDR_L, 8'(((r & 31) << 3) | bitpos));
  endtask

  task automatic sense_row(input int b, input int r, output logic [7:0] v);
    set_addr(b, r, 0);
    wr(OFF_CMD, CMD_SENSE);
    wait_idle();
    rd(OFF_DATA, v);
  endtask

  task automatic prog_bit(input int b, input int r, input int bitpos);
    set_addr(b, r, bitpos);
    wr(OFF_CMD, CMD_PROG);
    wait_idle();
  endtask

  task automatic busy_len(input logic [7:0] cmd, output int n);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = AW'(OFF_CMD); bus_wdata = cmd;
    @(negedge clk);
    bus_we = 1'b0; bus_re = 1'b1; bus_addr = AW'(OFF_STATUS);
    n = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (bus_rdata[7]) n++;
      else break;
    end
    bus_re = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n;
    for (int i = 0; i < BANKS*ROWS; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R11 R12: reset state of registers
    rd(OFF_STATUS, v); check("R11 status after reset", v, 8'h00);
    rd(OFF_ERR, v);    check("R11 error after reset", v, 8'h00);
    rd(OFF_PROT, v);   check("R11 protection after reset", v, 8'h00);
    rd(OFF_DATA, v);   check("R11 data after reset", v, 8'h00);
    wr(OFF_MASK, 8'h5A);
    rd(OFF_MASK, v);   check("R12 mask readback", v, 8'h5A);
    rd('h3C, v);       check("R12 unmapped reads zero", v, 8'h00);

    // R5: locked program
    wr(OFF_MASK, 8'h03);
    wr(OFF_ERR, 8'hFE);
    prog_bit(2, 5, 3);
    rd(OFF_ERR, v);    check("R5 locked error code", v, 8'h08);
    rd(OFF_STATUS, v); check("R5 locked done and not busy", v, 8'h01);
    rd(shadow_addr(2, 5), v); check("R5 locked shadow unchanged", v, 8'h00);
    sense_row(2, 5, v);       check("R5 locked row unchanged", v, 8'h00);
    wr(OFF_ERR, 8'hFE);
    rd(OFF_ERR, v);    check("R7 error cleared", v, 8'h00);
    wr(OFF_STATUS, 8'h03);
    rd(OFF_STATUS, v); check("R7 status cleared", v, 8'h00);

    // R4: busy duration
    set_addr(7, 31, 0);
    busy_len(CMD_SENSE, n);
    check("R4 sense busy cycles", 8'(n), 8'(SC));
    wr(OFF_PROT, UNLOCK_KEY);
    set_addr(7, 31, 7);
    busy_len(CMD_PROG, n);
    check("R4 program busy cycles", 8'(n), 8'(PC));
    model[7*ROWS+31] = 8'h80;
    rd(OFF_STATUS, v); check("R3 program done flag", v, 8'h03);
    wr(OFF_STATUS, 8'h03);

    // R1 R3: sweep over every bank and row
    for (int b = 0; b < BANKS; b++) begin
      for (int r = 0; r < ROWS; r++) begin
        int b1;
        b1 = (b * 5 + r) % 8;
        prog_bit(b, r, b1);
        model[b*ROWS+r] |= 8'(1 << b1);
        if (r % 4 == 0) begin
          int b2;
          b2 = (b + r + 3) % 8;
          prog_bit(b, r, b2);
          model[b*ROWS+r] |= 8'(1 << b2);
        end
      end
    end
    // R2 R9: sense and shadow both reproduce the model
    for (int b = 0; b < BANKS; b++) begin
      for (int r = 0; r < ROWS; r++) begin
        sense_row(b, r, v);
        check($sformatf("R1 R2 sense bank %0d row %0d", b, r), v, model[b*ROWS+r]);
        rd(shadow_addr(b, r), v);
        check($sformatf("R9 shadow bank %0d row %0d", b, r), v, model[b*ROWS+r]);
      end
    end
    rd(OFF_ERR, v); check("R3 sweep raised no error", v, 8'h00);

    // R6: reprogram an already set bit, then another bit
    prog_bit(0, 0, 0);
    sense_row(0, 0, v);
    check("R6 reprogram keeps row", v, model[0] | 8'h01);
    model[0] |= 8'h01;
    prog_bit(0, 0, 6);
    model[0] |= 8'h40;
    sense_row(0, 0, v); check("R6 other bits kept", v, model[0]);

    // R8: out of range row
    wr(OFF_STATUS, 8'h03);
    wr(OFF_ADDR_H, 8'((3 << 3) | 1));
    wr(OFF_ADDR_L, 8'h05);
    wr(OFF_CMD, CMD_PROG);
    wait_idle();
    rd(OFF_ERR, v);    check("R8 program range error", v, 8'h02);
    rd(OFF_STATUS, v); check("R8 program done", v, 8'h01);
    wr(OFF_ERR, 8'hFE);
    wr(OFF_ADDR_L, 8'h00);
    wr(OFF_CMD, CMD_SENSE);
    wait_idle();
    rd(OFF_DATA, v);   check("R8 sense data zero", v, 8'h00);
    rd(OFF_ERR, v);    check("R8 sense range error", v, 8'h02);
    sense_row(3, 0, v); check("R8 neighbour row unchanged", v, model[3*ROWS]);
    wr(OFF_ERR, 8'hFE);

    // R10: command while busy, unknown command
    wr(OFF_STATUS, 8'h03);
    set_addr(1, 1, 2);
    @(negedge clk); bus_we = 1'b1; bus_addr = AW'(OFF_CMD); bus_wdata = CMD_SENSE;
    @(negedge clk); bus_wdata = CMD_PROG;
    @(negedge clk); bus_we = 1'b0;
    wait_idle();
    rd(OFF_STATUS, v); check("R10 only sense completed", v, 8'h02);
    sense_row(1, 1, v); check("R10 row not programmed", v, model[ROWS+1]);
    wr(OFF_STATUS, 8'h03);
    wr(OFF_CMD, 8'h55);
    rd(OFF_STATUS, v); check("R10 unknown command ignored", v, 8'h00);

    // R7: clear lands on the completion edge of a sense
    set_addr(4, 9, 0);
    @(negedge clk); bus_we = 1'b1; bus_addr = AW'(OFF_CMD); bus_wdata = CMD_SENSE;
    @(negedge clk); bus_we = 1'b0;
    repeat (SC - 1) @(negedge clk);
    bus_we = 1'b1; bus_addr = AW'(OFF_STATUS); bus_wdata = 8'h03;
    @(negedge clk); bus_we = 1'b0;
    rd(OFF_STATUS, v); check("R7 done survives same cycle clear", v, 8'h02);
    // R7: error clear lands on the completion edge of a locked program
    wr(OFF_PROT, 8'h00);
    set_addr(4, 9, 1);
    @(negedge clk); bus_we = 1'b1; bus_addr = AW'(OFF_CMD); bus_wdata = CMD_PROG;
    @(negedge clk); bus_we = 1'b0;
    repeat (PC - 1) @(negedge clk);
    bus_we = 1'b1; bus_addr = AW'(OFF_ERR); bus_wdata = 8'hFE;
    @(negedge clk); bus_we = 1'b0;
    rd(OFF_ERR, v); check("R7 error survives same cycle clear", v, 8'h08);
    sense_row(4, 9, v); check("R5 locked row unchanged", v, model[4*ROWS+9]);

    // R9: window writes ignored
    wr(shadow_addr(5, 7), 8'hFF);
    rd(shadow_addr(5, 7), v); check("R9 window write ignored", v, model[5*ROWS+7]);

    // R11: reset keeps fuses
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    rd(OFF_ERR, v);    check("R11 error cleared by reset", v, 8'h00);
    rd(OFF_STATUS, v); check("R11 status cleared by reset", v, 8'h00);
    sense_row(6, 20, v); check("R11 fuses kept over reset", v, model[6*ROWS+20]);
    rd(shadow_addr(6, 21), v); check("R11 shadow kept over reset", v, model[6*ROWS+21]);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule